// File: doc/BRIEF.md
# A/D Trigger and Scan Sequencer

This block decides when an analog-to-digital converter begins a conversion. A start event comes from one of three places: a software start command written through the configuration port, a tick from an on-chip timer, or a rising edge on an external trigger pin. A hardware-enable bit chooses between software and hardware starts. A source-select bit chooses which hardware source is used.

One accepted trigger produces either a single conversion or a scan. A single conversion uses the low channel. A scan walks from the low channel up to the high channel. Each channel gets one start pulse to the converter. The sequencer then waits for the converter's done pulse, and after that waits out a fixed gap before the next channel. The gap is one of two cycle counts. A readable status byte reports the sequencer busy flag, a D/A busy input, and the configuration bits. A sticky overrun flag records any trigger that arrived while the sequencer was busy.

The configuration port is register-style. On a cycle with `cfg_wr_i` high:
- Address 0 loads the mode byte.
- Address 1 loads the low channel.
- Address 2 loads the high channel.
- Address 3 with data bit 0 set issues a software start.

Top module: `adc_trig_seq`

## Requirements
- R1: Status bit 7 (busy) is 1 from the cycle after a trigger is accepted until the final done pulse, including every inter-sample gap. It is 0 whenever the sequencer is idle.
- R2: Mode byte (address 0) bits are: bit 0 hardware source (1 = timer, 0 = external pin), bit 1 hardware enable, bit 2 gap select, bit 3 timer-0 frequency, bit 4 timer-1 frequency, bit 5 timer-1 clock source, bit 6 scan enable. With hardware enable 0, a write to address 3 with bit 0 set starts the sequencer, and timer ticks and external edges are ignored.
- R3: With hardware enable 1, software start writes have no effect. Source bit 1 accepts only timer ticks, and source bit 0 accepts only external pin edges.
- R4: The external pin passes through a two-flop synchroniser. Only a rising edge triggers, so holding the pin high produces a single start.
- R5: With scan enable 0, a trigger produces exactly one converter start pulse, on the low channel.
- R6: With scan enable 1, a trigger produces one start pulse per channel, from the low channel up to the high channel inclusive, in ascending order. Each start is one cycle wide, and each start after the first follows the previous channel's done pulse. If low is greater than or equal to high, a scan makes one conversion.
- R7: Within a scan, the next start rises exactly G cycles after the clock edge that samples the done pulse. G is 50 when the gap select bit is 1, and 93 when it is 0.
- R8: A trigger from the enabled source that arrives while busy is ignored and sets `ovr_o`. A pulse on `stat_rd_i` clears `ovr_o`, but a new overrun in the same cycle wins.
- R9: The clock edge that samples the last channel's done pulse also returns the sequencer to idle, so busy reads 0 in the following cycle.
- R10: Status bits 7 down to 0 are: busy, D/A busy input, timer-1 clock source, timer-1 frequency, timer-0 frequency, gap select, hardware enable, hardware source.
- R11: After reset, the status byte reads 0, `conv_start_o` is 0 and `ovr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| stat_rd_i | input | 1 | Status read strobe; clears the overrun flag |
| ext_trig_i | input | 1 | Asynchronous external trigger pin |
| tmr_tick_i | input | 1 | One-cycle tick from timer 0 |
| dac_busy_i | input | 1 | D/A busy, reported in the status byte |
| conv_done_i | input | 1 | One-cycle converter done pulse |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| conv_chan_o | output | CH_W | Channel for the current conversion |
| stat_o | output | 8 | Status byte |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions assume the following about the inputs:
- `conv_done_i` is a one-cycle pulse that arrives only after a start and before the next start.
- The channel bounds and mode byte are not rewritten while busy is 1.
- The timer tick is at most one cycle wide.

The bench drives its converter model so that done follows each start by a fixed latency. It changes configuration only after waiting for busy to fall. It drives every input at the falling edge, so the synchroniser and the sequencer see clean values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CONV, SQ_GAP} seq_state_t;

  typedef struct packed {
    logic scan_en;
    logic t1_src;
    logic t1_frq;
    logic t0_frq;
    logic gap_short;
    logic hw_en;
    logic src_timer;
  } mode_t;
endpackage

// File: rtl/adc_ext_sync.sv
module adc_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  // R4
  edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/adc_trig_arb.sv
module adc_trig_arb (
  input  logic hw_en_i,
  input  logic src_timer_i,
  input  logic sw_start_i,
  input  logic tick_i,
  input  logic ext_rise_i,
  output logic trig_o
);
  logic hw_trig;

  always_comb begin
    hw_trig = src_timer_i ? tick_i : ext_rise_i;
    trig_o  = hw_en_i ? hw_trig : sw_start_i;
  end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W      = 4,
  parameter int GAP_SHORT = 50,
  parameter int GAP_LONG  = 93
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  input  logic            scan_en_i,
  input  logic            gap_short_i,
  input  logic [CH_W-1:0] lo_i,
  input  logic [CH_W-1:0] hi_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic            start_o,
  output logic [CH_W-1:0] chan_o
);
  localparam int GAP_MAX = (GAP_SHORT > GAP_LONG) ? GAP_SHORT : GAP_LONG;
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam logic [GW-1:0] LOAD_S = GW'(GAP_SHORT - 1);
  localparam logic [GW-1:0] LOAD_L = GW'(GAP_LONG - 1);

  seq_state_t      st_q;
  logic [GW-1:0]   gcnt_q;
  logic [CH_W-1:0] chan_q;
  logic            start_q;
  logic            last_ch;

  assign last_ch = !scan_en_i || (chan_q >= hi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      gcnt_q  <= '0;
      chan_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (trig_i) begin
          st_q    <= SQ_CONV;
          chan_q  <= lo_i;
          start_q <= 1'b1;
        end
        SQ_CONV: if (done_i) begin
          if (last_ch) st_q <= SQ_IDLE;
          else begin
            st_q   <= SQ_GAP;
            gcnt_q <= gap_short_i ? LOAD_S : LOAD_L;
          end
        end
        SQ_GAP: begin
          if (gcnt_q == '0) begin
            st_q    <= SQ_CONV;
            chan_q  <= chan_q + 1'b1;
            start_q <= 1'b1;
          end else gcnt_q <= gcnt_q - 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign start_o = start_q;
  assign chan_o  = chan_q;

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R9
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_CONV && done_i && last_ch) |=> !busy_o);
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_W      = 4,
  parameter int GAP_SHORT = 50,
  parameter int GAP_LONG  = 93
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [7:0]      cfg_wdata_i,
  input  logic            stat_rd_i,
  input  logic            ext_trig_i,
  input  logic            tmr_tick_i,
  input  logic            dac_busy_i,
  input  logic            conv_done_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_chan_o,
  output logic [7:0]      stat_o,
  output logic            ovr_o
);
  mode_t           mode_q;
  logic [CH_W-1:0] lo_q, hi_q;
  logic            ovr_q, sw_start, ext_rise, trig, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (cfg_wr_i) begin
      unique case (cfg_addr_i)
        2'd0:    mode_q <= mode_t'(cfg_wdata_i[6:0]);
        2'd1:    lo_q   <= cfg_wdata_i[CH_W-1:0];
        2'd2:    hi_q   <= cfg_wdata_i[CH_W-1:0];
        default: ;
      endcase
    end
  end

  assign sw_start = cfg_wr_i && (cfg_addr_i == 2'd3) && cfg_wdata_i[0];

  adc_ext_sync i_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_trig_i), .rise_o(ext_rise));

  adc_trig_arb i_arb (
    .hw_en_i(mode_q.hw_en), .src_timer_i(mode_q.src_timer),
    .sw_start_i(sw_start), .tick_i(tmr_tick_i), .ext_rise_i(ext_rise),
    .trig_o(trig));

  adc_scan_fsm #(.CH_W(CH_W), .GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)) i_fsm (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .scan_en_i(mode_q.scan_en),
    .gap_short_i(mode_q.gap_short), .lo_i(lo_q), .hi_i(hi_q),
    .done_i(conv_done_i), .busy_o(busy), .start_o(conv_start_o),
    .chan_o(conv_chan_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ovr_q <= 1'b0;
    else if (busy && trig) ovr_q <= 1'b1;
    else if (stat_rd_i)    ovr_q <= 1'b0;
  end

  assign ovr_o  = ovr_q;
  assign stat_o = {busy, dac_busy_i, mode_q.t1_src, mode_q.t1_frq,
                   mode_q.t0_frq, mode_q.gap_short, mode_q.hw_en,
                   mode_q.src_timer};

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> ovr_o);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig) |=> !busy);
  // R3
  sw_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.hw_en && !busy && sw_start && !tmr_tick_i && !ext_rise) |=> !busy);
endmodule

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
  localparam int CH_W = 4;
  localparam int LAT  = 6;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, stat_rd = 0, ext = 0, tick = 0, dac_busy = 0, done = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic start, ovr;
  logic [CH_W-1:0] chan;
  logic [7:0] stat;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int nstart = 0, lat = 0, t_done = 0, last_gap = 0;
  int ch_log[16];
  logic done_prev = 0, busy_after_done = 0;
  int busy_hi_gaps = 0;
  bit fin = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_trig_seq #(.CH_W(CH_W)) i_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .stat_rd_i(stat_rd), .ext_trig_i(ext),
    .tmr_tick_i(tick), .dac_busy_i(dac_busy), .conv_done_i(done),
    .conv_start_o(start), .conv_chan_o(chan), .stat_o(stat), .ovr_o(ovr));

  // converter model and monitor, all at the falling edge
  always @(negedge clk) begin
    if (done_prev) busy_after_done = stat[7];
    if (done_prev && stat[7]) busy_hi_gaps++;
    done_prev = done;
    done = 0;
    if (start) begin
      if (nstart < 16) ch_log[nstart] = int'(chan);
      if (nstart > 0) last_gap = cyc - t_done;
      nstart++;
      lat = LAT;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) begin done = 1; t_done = cyc; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; addr = a; wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic idle_wait();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!stat[7] && lat == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(stat == 8'h00, "R11 status", stat, 0);
    chk(!start && !ovr, "R11 start/ovr", {start, ovr}, 0);
  endtask

  task automatic t_sw_single();
    int n0;
    wr(2'd1, 8'd5); wr(2'd2, 8'd9); wr(2'd0, 8'h00);
    n0 = nstart;
    wr(2'd3, 8'h01);
    chk(stat[7], "R1 busy after start", stat[7], 1);
    idle_wait();
    chk(nstart == n0 + 1, "R5 single start count", nstart - n0, 1);
    chk(ch_log[n0] == 5, "R5 channel = low", ch_log[n0], 5);
    chk(!busy_after_done, "R9 idle after done", busy_after_done, 0);
    n0 = nstart;
    pulse_tick();
    ext = 1; repeat (5) @(negedge clk); ext = 0;
    idle_wait();
    chk(nstart == n0, "R2 hw sources ignored", nstart - n0, 0);
  endtask

  task automatic t_hw_timer();
    int n0;
    wr(2'd0, 8'h03);
    n0 = nstart;
    wr(2'd3, 8'h01);
    repeat (4) @(negedge clk);
    chk(nstart == n0 && !stat[7], "R3 sw start locked out", nstart - n0, 0);
    ext = 1; repeat (5) @(negedge clk); ext = 0;
    idle_wait();
    chk(nstart == n0, "R3 ext ignored with timer src", nstart - n0, 0);
    pulse_tick();
    idle_wait();
    chk(nstart == n0 + 1, "R3 timer tick starts", nstart - n0, 1);
  endtask

  task automatic t_hw_ext();
    int n0;
    wr(2'd0, 8'h02);
    n0 = nstart;
    pulse_tick();
    idle_wait();
    chk(nstart == n0, "R3 tick ignored with ext src", nstart - n0, 0);
    ext = 1;
    repeat (40) @(negedge clk);
    chk(nstart == n0 + 1, "R4 held pin gives one start", nstart - n0, 1);
    ext = 0;
    idle_wait();
  endtask

  task automatic t_scan(input bit short_gap, input int lo, input int hi);
    int n0, g, exp_n;
    g = short_gap ? 50 : 93;
    exp_n = (hi > lo) ? hi - lo + 1 : 1;
    wr(2'd1, 8'(lo)); wr(2'd2, 8'(hi));
    wr(2'd0, short_gap ? 8'h44 : 8'h40);
    n0 = nstart; busy_hi_gaps = 0;
    wr(2'd3, 8'h01);
    idle_wait();
    chk(nstart == n0 + exp_n, "R6 scan start count", nstart - n0, exp_n);
    for (int k = 0; k < exp_n; k++)
      chk(ch_log[n0 + k] == lo + k, "R6 scan channel order", ch_log[n0 + k], lo + k);
    if (exp_n > 1) begin
      chk(last_gap == g + 1, "R7 gap cycles (+1 sample offset)", last_gap, g + 1);
      chk(busy_hi_gaps == exp_n - 1, "R1 busy held in gaps", busy_hi_gaps, exp_n - 1);
    end
    chk(!busy_after_done, "R9 busy clears with last done", busy_after_done, 1'b0);
  endtask

  task automatic t_overrun();
    int n0;
    wr(2'd1, 8'd1); wr(2'd0, 8'h03);
    n0 = nstart;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    chk(ovr, "R8 overrun set", ovr, 1);
    idle_wait();
    chk(nstart == n0 + 1, "R8 busy trigger ignored", nstart - n0, 1);
    chk(ovr, "R8 overrun sticky", ovr, 1);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    chk(!ovr, "R8 read clears", ovr, 0);
  endtask

  task automatic t_status();
    wr(2'd0, 8'h3B); dac_busy = 1;
    @(negedge clk);
    chk(stat == 8'h7B, "R10 status layout", stat, 8'h7B);
    wr(2'd0, 8'h04); dac_busy = 0;
    @(negedge clk);
    chk(stat == 8'h04, "R10 gap bit position", stat, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sw_single();
    t_hw_timer();
    t_hw_ext();
    t_scan(1'b1, 2, 5);
    t_scan(1'b0, 7, 9);
    t_scan(1'b1, 4, 4);
    t_overrun();
    t_status();
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule